// File: doc/BRIEF.md
# Two-Limit Watchdog Comparator

This block carries out the limit check of a sequencer's watchdog instruction. A converted sample arrives with a valid strobe and a step select. The step select says whether the sample is checked against the first limit or the second limit. Each limit has its own sense bit. When the sense bit is 1, a sample above the limit is a violation. When it is 0, a sample below the limit is a violation. A sample equal to the limit is never a violation. Samples and limits are signed two's complement values.

A violation raises a one-cycle watchdog event. It also sets a sticky bit in a 16-bit status word. The bit records which limit was crossed and which of the eight sequencer instructions was running. Software reads the status word through `stat_q`. Pulsing `stat_rd` for one cycle clears the word. A violation that lands in the same cycle as the read is kept.

The reset input is asserted asynchronously and released through an internal two-stage synchronizer. The block is therefore idle for two clock edges after `rst_n` rises.

Top module: `wdog_dual_limit`

## Requirements
- R1: While the block is in reset, and after it leaves reset, `wd_event` is 0 and `stat_q` is 0 until a violation occurs.
- R2: With the selected limit's sense bit at 1, a valid sample strictly greater than that limit is a violation.
- R3: With the selected limit's sense bit at 0, a valid sample strictly less than that limit is a violation.
- R4: A valid sample exactly equal to the selected limit is not a violation, whatever the sense bit.
- R5: `smp_step` = 0 applies `lim1_val` and `lim1_above`. `smp_step` = 1 applies `lim2_val` and `lim2_above`. The other limit has no effect on the result.
- R6: `wd_event` is high for exactly the one cycle after a valid violating sample. It stays low after cycles with `smp_vld` = 0.
- R7: A violation of limit 1 sets `stat_q[instr_num]`. A violation of limit 2 sets `stat_q[8+instr_num]`. These bits stay set until cleared, and they are visible one cycle after the sample.
- R8: A cycle with `stat_rd` = 1 clears every status bit at the next edge, except a bit set by a violation in that same cycle.
- R9: Comparisons are signed over 13 bits, so a negative sample is below any non-negative limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_step | input | 1 | 0 = check against limit 1, 1 = check against limit 2 |
| smp_data | input | 13 | Signed converted sample |
| lim1_val | input | 13 | Signed limit 1 |
| lim1_above | input | 1 | Limit 1 sense: 1 = above is a violation, 0 = below is a violation |
| lim2_val | input | 13 | Signed limit 2 |
| lim2_above | input | 1 | Limit 2 sense |
| instr_num | input | 3 | Number of the executing instruction |
| stat_rd | input | 1 | Read strobe that clears the status word |
| wd_event | output | 1 | Watchdog violation event, one cycle long |
| stat_q | output | 16 | Sticky status: [7:0] limit 1 per instruction, [15:8] limit 2 per instruction |

## Verification
Suppose the comparator's direction or equality handling is wrong, or the limit select is swapped. Then `wd_event` shows a wrong value in the very cycle after the offending sample, and the stray or missing status bit appears in `stat_q` in that same cycle. A status register that loses its stickiness, or clears set bits on a read, only shows up on a later cycle, when `stat_q` no longer holds the accumulated value. The bench therefore compares the full status word every cycle. It also mixes read strobes into the violation traffic, including reads in the same cycle as a violation.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WD_DATA_W  = 13;
  localparam int unsigned WD_INSTR_W = 3;
  localparam int unsigned WD_N_LIM   = 2;

  typedef enum logic {
    STEP_LIM1 = 1'b0,
    STEP_LIM2 = 1'b1
  } wd_step_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/wdog_limit_cmp.sv
module wdog_limit_cmp #(
  parameter int unsigned DATA_W = 13
) (
  input  logic signed [DATA_W-1:0] smp,
  input  logic signed [DATA_W-1:0] lim,
  input  logic                     above,
  output logic                     viol
);
  logic gt, lt;

  always_comb begin
    gt   = (smp > lim);
    lt   = (smp < lim);
    viol = above ? gt : lt;
  end
endmodule

// File: rtl/wdog_stat_reg.sv
module wdog_stat_reg #(
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_s,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr,
  output logic [STAT_W-1:0] q
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              stat_en;

  always_comb begin
    stat_en = clr || (set_vec != '0);
    stat_d  = (clr ? '0 : stat_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign q = stat_q;

  // R7: bits are sticky while no read is pending
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_s)
    !clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8: a read with no new violation empties the register
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (clr && set_vec == '0) |=> (stat_q == '0));

  // R7: a set request always shows up after the edge
  assert_set_visible_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/wdog_dual_limit.sv
module wdog_dual_limit
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W  = WD_DATA_W,
  parameter int unsigned INSTR_W = WD_INSTR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_vld,
  input  logic                      smp_step,
  input  logic signed [DATA_W-1:0]  smp_data,
  input  logic signed [DATA_W-1:0]  lim1_val,
  input  logic                      lim1_above,
  input  logic signed [DATA_W-1:0]  lim2_val,
  input  logic                      lim2_above,
  input  logic [INSTR_W-1:0]        instr_num,
  input  logic                      stat_rd,
  output logic                      wd_event,
  output logic [2*(1<<INSTR_W)-1:0] stat_q
);
  localparam int unsigned N_LIM   = WD_N_LIM;
  localparam int unsigned N_INSTR = 1 << INSTR_W;
  localparam int unsigned STAT_W  = N_LIM * N_INSTR;

  logic                     rst_s;
  logic signed [DATA_W-1:0] lim_arr [N_LIM];
  logic [N_LIM-1:0]         dir_vec;
  logic [N_LIM-1:0]         viol_vec;
  logic [STAT_W-1:0]        set_vec;
  logic                     sel_viol;
  logic                     evt_d, evt_q;

  wdog_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  assign lim_arr[0] = lim1_val;
  assign lim_arr[1] = lim2_val;
  assign dir_vec    = {lim2_above, lim1_above};

  for (genvar g = 0; g < N_LIM; g++) begin : g_lim
    wdog_limit_cmp #(.DATA_W(DATA_W)) u_cmp (
      .smp   (smp_data),
      .lim   (lim_arr[g]),
      .above (dir_vec[g]),
      .viol  (viol_vec[g])
    );
    for (genvar i = 0; i < N_INSTR; i++) begin : g_ins
      assign set_vec[g*N_INSTR + i] = smp_vld && (smp_step == 1'(g))
                                      && viol_vec[g]
                                      && (instr_num == INSTR_W'(i));
    end
  end

  always_comb begin
    sel_viol = (smp_step == STEP_LIM2) ? viol_vec[1] : viol_vec[0];
    evt_d    = smp_vld && sel_viol;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  wdog_stat_reg #(.STAT_W(STAT_W)) u_stat (
    .clk     (clk),
    .rst_s   (rst_s),
    .set_vec (set_vec),
    .clr     (stat_rd),
    .q       (stat_q)
  );

  assign wd_event = evt_q;

  // R6: no event unless a sample was presented one cycle earlier
  assert_evt_needs_vld_R6: assert property (@(posedge clk) disable iff (!rst_s)
    wd_event |-> $past(smp_vld));

  // R4: equality on limit 1 never raises an event
  assert_eq_lim1_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (smp_vld && !smp_step && smp_data == lim1_val) |=> !wd_event);

  // R4: equality on limit 2 never raises an event
  assert_eq_lim2_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (smp_vld && smp_step && smp_data == lim2_val) |=> !wd_event);

  // R2: above-sense crossing on limit 1 raises the event
  assert_above_lim1_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (smp_vld && !smp_step && lim1_above && smp_data > lim1_val) |=> wd_event);

  // R3: below-sense crossing on limit 2 raises the event
  assert_below_lim2_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (smp_vld && smp_step && !lim2_above && smp_data < lim2_val) |=> wd_event);

  // R7: at most one status bit is requested per sample
  assert_one_set_R7: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(set_vec));

  // R7: an event is always backed by a status bit
  assert_evt_logged_R7: assert property (@(posedge clk) disable iff (!rst_s)
    wd_event |-> (stat_q != '0));
endmodule

// File: tb/sim_wdog_dual_limit.sv
module sim_wdog_dual_limit;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               smp_vld, smp_step, lim1_above, lim2_above, stat_rd;
  logic signed [12:0] smp_data, lim1_val, lim2_val;
  logic [2:0]         instr_num;
  logic               wd_event;
  logic [15:0]        stat_q;

  int          n_run  = 0;
  int          n_fail = 0;
  bit          exp_evt;
  logic [15:0] exp_stat;
  string       evt_tag;

  always #10 clk = ~clk;

  wdog_dual_limit u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_step(smp_step),
    .smp_data(smp_data), .lim1_val(lim1_val), .lim1_above(lim1_above),
    .lim2_val(lim2_val), .lim2_above(lim2_above), .instr_num(instr_num),
    .stat_rd(stat_rd), .wd_event(wd_event), .stat_q(stat_q)
  );

  function automatic bit crosses(logic signed [12:0] s, logic signed [12:0] l, bit up);
    if (up) return s > l;
    return s < l;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic cyc(bit v, bit st, logic signed [12:0] d,
                     logic signed [12:0] l1, bit a1,
                     logic signed [12:0] l2, bit a2,
                     logic [2:0] ins, bit rd, string tag);
    bit          hit;
    logic [15:0] setb;
    smp_vld = v; smp_step = st; smp_data = d;
    lim1_val = l1; lim1_above = a1; lim2_val = l2; lim2_above = a2;
    instr_num = ins; stat_rd = rd;
    hit  = v && (st ? crosses(d, l2, a2) : crosses(d, l1, a1));
    setb = '0;
    if (hit) setb[{st, ins}] = 1'b1;
    exp_evt  = hit;
    exp_stat = (rd ? 16'h0 : exp_stat) | setb;
    evt_tag  = tag;
    @(negedge clk);
    chk(evt_tag, {15'b0, wd_event}, {15'b0, exp_evt});
    chk(rd ? "R8" : "R7", stat_q, exp_stat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0013));
    rst_n = 1'b0; smp_vld = 0; smp_step = 0; smp_data = 0;
    lim1_val = 0; lim1_above = 0; lim2_val = 0; lim2_above = 0;
    instr_num = 0; stat_rd = 0;
    exp_stat = '0;
    repeat (3) @(negedge clk);
    chk("R1", {15'b0, wd_event}, 16'h0);
    chk("R1", stat_q, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {15'b0, wd_event}, 16'h0);
    chk("R1", stat_q, 16'h0);

    // directed corner cases
    cyc(1, 0, 13'sd101, 13'sd100, 1, 13'sd0, 0, 3'd2, 0, "R2");
    cyc(1, 0, 13'sd100, 13'sd100, 1, 13'sd0, 0, 3'd3, 0, "R4");
    cyc(1, 1, 13'sd49,  13'sd0,   0, 13'sd50, 0, 3'd5, 0, "R3");
    cyc(1, 1, 13'sd50,  13'sd0,   0, 13'sd50, 0, 3'd6, 0, "R4");
    cyc(0, 0, 13'sd900, 13'sd0,   1, 13'sd0,  1, 3'd1, 0, "R6");
    cyc(1, 1, 13'sd5,   13'sd0,   1, 13'sd10, 1, 3'd7, 0, "R5");
    cyc(1, 0, -13'sd1,  13'sd0,   0, 13'sd0,  1, 3'd0, 0, "R9");
    cyc(1, 1, -13'sd4096, -13'sd4096, 0, 13'sd4095, 0, 3'd4, 0, "R9");
    cyc(0, 0, 13'sd0,   13'sd0,   0, 13'sd0,  0, 3'd0, 1, "R8");
    cyc(1, 1, 13'sd20,  13'sd0,   0, 13'sd10, 1, 3'd1, 1, "R8");
    cyc(0, 0, 13'sd0,   13'sd0,   0, 13'sd0,  0, 3'd0, 0, "R7");
    cyc(0, 0, 13'sd0,   13'sd0,   0, 13'sd0,  0, 3'd0, 1, "R8");

    // constrained random traffic
    for (int k = 0; k < 3000; k++) begin
      logic signed [12:0] l1, l2, d;
      bit                 st;
      l1 = 13'($urandom);
      l2 = 13'($urandom);
      st = 1'($urandom);
      if ($urandom_range(1, 0) == 1)
        d = (st ? l2 : l1) + 13'($signed($urandom_range(6, 0)) - 3);
      else
        d = 13'($urandom);
      cyc($urandom_range(3, 0) != 0, st, d, l1, 1'($urandom), l2, 1'($urandom),
          3'($urandom), $urandom_range(15, 0) == 0, "R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule